// File: doc/BRIEF.md
# I2C Target Acknowledge Override Controller

This block sits beside the byte shifter of an I2C target receiver and decides who supplies the acknowledge bit for each received byte. When its override flag is clear, the hardware acknowledges every byte by itself. When the flag is set, every received byte raises a request to software. The ACK phase is held by stretching SCL until software writes the ACK or NACK value.

Software clears the flag. Hardware sets it at a protocol point that software arms ahead of time. There are three such points, and each has its own arming bit:
- on a START condition;
- after the acknowledge of the byte just before the PEC byte, so that software decides the acknowledge of the PEC byte;
- after the acknowledge of the PEC byte itself.

A byte counter clears on START and is compared against a programmed frame length, so the block knows which byte is the PEC byte. The counter wraps after the PEC byte, so consecutive frames are tracked without a new START.

A software clear is refused while a recent software NACK is still on the bus. The clear is accepted only after the NACK write plus two bit-period ticks. This keeps the NACK and the hand-back to hardware out of the same cycle.

Top module: `tgt_ack_override`

## Requirements
- R1: After reset, `ovrActive`, `ackBit`, `decisionReq` and `sclStall` are all 0.
- R2: The three arming bits are loaded together from `cfgArmPost`, `cfgArmPre` and `cfgArmStart` when `cfgWe` is 1, and each acts independently. With all three at 0, no event sets `ovrActive`.
- R3: With arm-after-PEC set, `ovrActive` becomes 1 in the cycle after the `ackDone` pulse of byte index `frameLen-1`. Byte indices start at 0 at the first byte after START.
- R4: With arm-before-PEC set and `frameLen` at least 2, `ovrActive` becomes 1 in the cycle after the `ackDone` pulse of byte index `frameLen-2`.
- R5: With arm-on-START set, `ovrActive` becomes 1 in the cycle after a `startSeen` pulse.
- R6: No hardware event clears `ovrActive`. It falls only in the cycle after an accepted `swClr`.
- R7: A `byteRcvd` pulse while `ovrActive` is 0 gives `ackBit` = 0 (ACK) in the next cycle and raises no request.
- R8: A `byteRcvd` pulse while `ovrActive` is 1 raises `decisionReq` and `sclStall` in the next cycle. Both hold until a `swAckWe` write.
  - After that write, `ackBit` equals `swNack` (1 = NACK, 0 = ACK) and the request drops in the next cycle.
  - A `swAckWe` write with no request pending is ignored.
- R9: A `swClr` in the same cycle as an accepted NACK write is ignored. So is any `swClr` before two `bitTick` pulses have followed that write.
- R10: If a set event and an accepted `swClr` fall in the same cycle, `ovrActive` ends up 1.
- R11: The byte counter returns to index 0 on `startSeen`, and after the PEC byte's `ackDone`. The following frame's PEC byte is therefore found without a new START.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startSeen | input | 1 | One-cycle pulse: START condition detected |
| byteRcvd | input | 1 | One-cycle pulse: a data byte has been shifted in and its ACK phase begins |
| ackDone | input | 1 | One-cycle pulse: ACK/NACK phase of the current byte completed |
| bitTick | input | 1 | One-cycle pulse once per bit period |
| frameLen | input | CNT_W | Bytes per frame including the PEC byte, 1 or more |
| cfgWe | input | 1 | Loads the three arming bits |
| cfgArmPost | input | 1 | Arm after the PEC byte is acknowledged |
| cfgArmPre | input | 1 | Arm before the PEC byte |
| cfgArmStart | input | 1 | Arm on START |
| swClr | input | 1 | Software writes the override enable to 0 |
| swAckWe | input | 1 | Software writes its acknowledge decision |
| swNack | input | 1 | Decision value: 1 = NACK, 0 = ACK |
| ovrActive | output | 1 | Sticky override status |
| ackBit | output | 1 | Acknowledge bit for the shifter to drive (0 = ACK) |
| decisionReq | output | 1 | Software decision pending |
| sclStall | output | 1 | Hold SCL low while the decision is pending |

## Verification
Some properties are checked on every cycle:
- the flag falls only after a software clear;
- hardware-mode bytes never raise a request and get ACK;
- a request appears only for a byte received under override, and waits for the software write;
- a NACK write never lets a same-cycle clear through.

Other behaviour only the bench's scenarios can show. These are the exact byte at which each arming mode fires, across a sweep of frame lengths, including counter wrap into the next frame. They also include the two-tick guard window, and the set-beats-clear collision.

// File: rtl/tgt_ack_pkg.sv
package tgt_ack_pkg;

  typedef struct packed {
    logic cntClear;
    logic cntStep;
    logic ackLoadHw;
    logic ackLoadSw;
    logic ackSwVal;
    logic guardLoad;
  } dpStrobes_t;

endpackage

// File: rtl/tgt_ack_dp.sv
module tgt_ack_dp
  import tgt_ack_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int GUARD_TICKS = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobes_t       strb,
  input  logic             bitTick,
  input  logic [CNT_W-1:0] frameLen,
  output logic             isPec,
  output logic             isPrePec,
  output logic             guardBusy,
  output logic             ackBit
);

  localparam int G_W = $clog2(GUARD_TICKS + 1);
  localparam logic [G_W-1:0] G_LOAD = G_W'(GUARD_TICKS);

  logic [CNT_W-1:0] byteCnt;
  logic [G_W-1:0]   guardCnt;
  logic             ackReg;

  // Position of the current byte within the frame
  assign isPec    = (byteCnt == frameLen - CNT_W'(1));
  assign isPrePec = (frameLen >= CNT_W'(2)) && (byteCnt == frameLen - CNT_W'(2));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      byteCnt <= '0;
    end else if (strb.cntClear) begin
      byteCnt <= '0;
    end else if (strb.cntStep) begin
      byteCnt <= isPec ? '0 : byteCnt + CNT_W'(1);
    end
  end

  // Bit-period guard after a software NACK
  always_ff @(posedge clk) begin
    if (!rstN) begin
      guardCnt <= '0;
    end else if (strb.guardLoad) begin
      guardCnt <= G_LOAD;
    end else if (bitTick && guardCnt != '0) begin
      guardCnt <= guardCnt - G_W'(1);
    end
  end

  assign guardBusy = (guardCnt != '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ackReg <= 1'b0;
    end else if (strb.ackLoadSw) begin
      ackReg <= strb.ackSwVal;
    end else if (strb.ackLoadHw) begin
      ackReg <= 1'b0;
    end
  end

  assign ackBit = ackReg;

endmodule

// File: rtl/tgt_ack_ctl.sv
module tgt_ack_ctl
  import tgt_ack_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startSeen,
  input  logic       byteRcvd,
  input  logic       ackDone,
  input  logic       cfgWe,
  input  logic       cfgArmPost,
  input  logic       cfgArmPre,
  input  logic       cfgArmStart,
  input  logic       swClr,
  input  logic       swAckWe,
  input  logic       swNack,
  input  logic       isPec,
  input  logic       isPrePec,
  input  logic       guardBusy,
  output dpStrobes_t strb,
  output logic       ovrActive,
  output logic       decisionReq
);

  logic armPost, armPre, armStart;
  logic ovr, pend;
  logic setEv, clrOk;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      armPost  <= 1'b0;
      armPre   <= 1'b0;
      armStart <= 1'b0;
    end else if (cfgWe) begin
      armPost  <= cfgArmPost;
      armPre   <= cfgArmPre;
      armStart <= cfgArmStart;
    end
  end

  always_comb begin
    strb           = '0;
    strb.cntClear  = startSeen;
    strb.cntStep   = ackDone && !startSeen;
    strb.ackLoadHw = byteRcvd && !ovr;
    strb.ackLoadSw = pend && swAckWe;
    strb.ackSwVal  = swNack;
    strb.guardLoad = pend && swAckWe && swNack;
  end

  assign setEv = (armStart && startSeen) ||
                 (ackDone && ((armPost && isPec) || (armPre && isPrePec)));
  assign clrOk = swClr && !guardBusy && !strb.guardLoad;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ovr <= 1'b0;
    end else if (setEv) begin
      ovr <= 1'b1;
    end else if (clrOk) begin
      ovr <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pend <= 1'b0;
    end else if (strb.ackLoadSw) begin
      pend <= 1'b0;
    end else if (byteRcvd && ovr) begin
      pend <= 1'b1;
    end
  end

  assign ovrActive   = ovr;
  assign decisionReq = pend;

endmodule

// File: rtl/tgt_ack_override.sv
module tgt_ack_override
  import tgt_ack_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int GUARD_TICKS = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startSeen,
  input  logic             byteRcvd,
  input  logic             ackDone,
  input  logic             bitTick,
  input  logic [CNT_W-1:0] frameLen,
  input  logic             cfgWe,
  input  logic             cfgArmPost,
  input  logic             cfgArmPre,
  input  logic             cfgArmStart,
  input  logic             swClr,
  input  logic             swAckWe,
  input  logic             swNack,
  output logic             ovrActive,
  output logic             ackBit,
  output logic             decisionReq,
  output logic             sclStall
);

  dpStrobes_t strb;
  logic       isPec, isPrePec, guardBusy;

  tgt_ack_ctl uCtl (
    .clk(clk), .rstN(rstN), .startSeen(startSeen), .byteRcvd(byteRcvd),
    .ackDone(ackDone), .cfgWe(cfgWe), .cfgArmPost(cfgArmPost),
    .cfgArmPre(cfgArmPre), .cfgArmStart(cfgArmStart), .swClr(swClr),
    .swAckWe(swAckWe), .swNack(swNack), .isPec(isPec), .isPrePec(isPrePec),
    .guardBusy(guardBusy), .strb(strb), .ovrActive(ovrActive),
    .decisionReq(decisionReq)
  );

  tgt_ack_dp #(.CNT_W(CNT_W), .GUARD_TICKS(GUARD_TICKS)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .bitTick(bitTick),
    .frameLen(frameLen), .isPec(isPec), .isPrePec(isPrePec),
    .guardBusy(guardBusy), .ackBit(ackBit)
  );

  assign sclStall = decisionReq;

endmodule

// File: rtl/tgt_ack_override_chk.sv
module tgt_ack_override_chk (
  input logic clk,
  input logic rstN,
  input logic byteRcvd,
  input logic swClr,
  input logic swAckWe,
  input logic swNack,
  input logic ovrActive,
  input logic ackBit,
  input logic decisionReq
);

  // R6: only a software clear can drop the flag
  a_r6_fall_needs_clear: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ovrActive) |-> $past(swClr));

  // R7: hardware mode acknowledges without a request
  a_r7_hw_ack: assert property (@(posedge clk) disable iff (!rstN)
    (byteRcvd && !ovrActive && !decisionReq) |=> (!ackBit && !decisionReq));

  // R8: a request appears only for a byte received under override
  a_r8_req_source: assert property (@(posedge clk) disable iff (!rstN)
    $rose(decisionReq) |-> $past(ovrActive && byteRcvd));

  // R8: the request waits for software
  a_r8_req_holds: assert property (@(posedge clk) disable iff (!rstN)
    (decisionReq && !swAckWe) |=> decisionReq);

  // R9: a clear alongside a NACK write is refused
  a_r9_nack_guard: assert property (@(posedge clk) disable iff (!rstN)
    (decisionReq && swAckWe && swNack && ovrActive) |=> ovrActive);

endmodule

bind tgt_ack_override tgt_ack_override_chk uChk (
  .clk(clk), .rstN(rstN), .byteRcvd(byteRcvd), .swClr(swClr),
  .swAckWe(swAckWe), .swNack(swNack), .ovrActive(ovrActive),
  .ackBit(ackBit), .decisionReq(decisionReq)
);

// File: tb/sim_tgt_ack_override.sv
`timescale 1ns/1ps
module sim_tgt_ack_override;

  localparam int CNT_W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startSeen = 0, byteRcvd = 0, ackDone = 0, bitTick = 0;
  logic [CNT_W-1:0] frameLen = 8'd3;
  logic cfgWe = 0, cfgArmPost = 0, cfgArmPre = 0, cfgArmStart = 0;
  logic swClr = 0, swAckWe = 0, swNack = 0;
  logic ovrActive, ackBit, decisionReq, sclStall;

  int nChecks = 0;
  int nFails  = 0;
  bit expOvr;
  int idx;

  always #2.5 clk = ~clk;

  tgt_ack_override #(.CNT_W(CNT_W)) u0 (
    .clk(clk), .rstN(rstN), .startSeen(startSeen), .byteRcvd(byteRcvd),
    .ackDone(ackDone), .bitTick(bitTick), .frameLen(frameLen), .cfgWe(cfgWe),
    .cfgArmPost(cfgArmPost), .cfgArmPre(cfgArmPre), .cfgArmStart(cfgArmStart),
    .swClr(swClr), .swAckWe(swAckWe), .swNack(swNack), .ovrActive(ovrActive),
    .ackBit(ackBit), .decisionReq(decisionReq), .sclStall(sclStall)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic configure(input bit post, input bit pre, input bit st);
    cfgArmPost = post; cfgArmPre = pre; cfgArmStart = st; cfgWe = 1;
    step(); cfgWe = 0;
  endtask

  task automatic clearOvr();
    swClr = 1; step(); swClr = 0;
  endtask

  // One byte: receive, decide if needed, complete the ACK phase
  task automatic doByte(input bit post, input bit pre, input bit nack);
    byteRcvd = 1; step(); byteRcvd = 0;
    if (expOvr) begin
      chk("R8 request", decisionReq, 1'b1);
      chk("R8 stall", sclStall, 1'b1);
      step();
      chk("R8 request held", decisionReq, 1'b1);
      swAckWe = 1; swNack = nack; step(); swAckWe = 0; swNack = 0;
      chk("R8 request drop", decisionReq, 1'b0);
      chk("R8 ack value", ackBit, nack);
    end else begin
      chk("R7 no request", decisionReq, 1'b0);
      chk("R7 hw ack", ackBit, 1'b0);
    end
    ackDone = 1; step(); ackDone = 0;
    if (post && idx == int'(frameLen) - 1) expOvr = 1;   // R3
    if (pre && frameLen >= 2 && idx == int'(frameLen) - 2) expOvr = 1; // R4
    idx = (idx == int'(frameLen) - 1) ? 0 : idx + 1;      // R11 wrap
    chk("R3/R4/R11 flag after ackDone", ovrActive, expOvr);
  endtask

  initial begin
    #(200000 * 5);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    step(); step();
    chk("R1 ovr reset", ovrActive, 1'b0);
    chk("R1 ack reset", ackBit, 1'b0);
    chk("R1 req reset", decisionReq, 1'b0);
    chk("R1 stall reset", sclStall, 1'b0);
    rstN = 1; step();
    chk("R1 ovr after release", ovrActive, 1'b0);

    // Sweep frame lengths and arming modes (R2..R5, R11)
    for (int len = 1; len <= 5; len++) begin
      for (int mode = 0; mode < 4; mode++) begin
        bit post, pre, st;
        post = (mode == 1); pre = (mode == 2); st = (mode == 3);
        frameLen = CNT_W'(len);
        configure(post, pre, st);
        clearOvr();
        chk("R6 cleared by software", ovrActive, 1'b0);
        startSeen = 1; step(); startSeen = 0;
        idx = 0;
        expOvr = st;
        chk("R5/R2 flag after START", ovrActive, expOvr);
        for (int b = 0; b < 2 * len + 1; b++) begin
          doByte(post, pre, 1'b0);
          if (mode == 0) chk("R2 unarmed stays clear", ovrActive, 1'b0);
        end
      end
    end

    // R8: decision write with nothing pending is ignored
    configure(0, 0, 0);
    clearOvr();
    byteRcvd = 1; step(); byteRcvd = 0;
    swAckWe = 1; swNack = 1; step(); swAckWe = 0; swNack = 0;
    chk("R8 stray write ack", ackBit, 1'b0);
    chk("R8 stray write req", decisionReq, 1'b0);

    // R9: NACK guard window
    frameLen = 8'd4;
    configure(0, 0, 1);
    startSeen = 1; step(); startSeen = 0;
    chk("R5 set", ovrActive, 1'b1);
    byteRcvd = 1; step(); byteRcvd = 0;
    swAckWe = 1; swNack = 1; swClr = 1; step(); swAckWe = 0; swNack = 0; swClr = 0;
    chk("R9 same-cycle clear refused", ovrActive, 1'b1);
    chk("R8 nack driven", ackBit, 1'b1);
    clearOvr();
    chk("R9 clear before ticks refused", ovrActive, 1'b1);
    bitTick = 1; step(); bitTick = 0;
    clearOvr();
    chk("R9 clear after one tick refused", ovrActive, 1'b1);
    bitTick = 1; step(); bitTick = 0;
    clearOvr();
    chk("R9 clear after two ticks accepted", ovrActive, 1'b0);
    chk("R6 fell on clear", ovrActive, 1'b0);

    // R10: set and clear together -> set wins
    startSeen = 1; swClr = 1; step(); startSeen = 0; swClr = 0;
    chk("R10 set beats clear from 0", ovrActive, 1'b1);
    startSeen = 1; swClr = 1; step(); startSeen = 0; swClr = 0;
    chk("R10 set beats clear from 1", ovrActive, 1'b1);

    // R6: hardware events never clear
    configure(0, 0, 0);
    startSeen = 1; step(); startSeen = 0;
    ackDone = 1; step(); ackDone = 0;
    bitTick = 1; step(); bitTick = 0;
    chk("R6 hw events keep flag", ovrActive, 1'b1);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule